// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block is a synchronous single-port SRAM whose data bus never needs an idle cycle when the traffic switches between reads and writes. Every operation is launched by registering an address and a command on a rising clock edge. A read returns its word two enabled edges later. A write takes its data two enabled edges after its address, which is the same slot in which a read would have returned data. The shared data timing lets any mix of reads and writes run at one operation per cycle.

Writes still waiting for their data, or for their commit to the array, sit in staging registers. A read that hits one of them is served the newest bytes by a per-lane merge. A two-bit burst counter can produce up to four addresses from one base, in linear or interleaved order. A clock enable freezes the whole pipeline. Three select inputs decode the chip select. The read-data drive enable is gated by an asynchronous output enable.

Top module: `zbt_sram_core`

## Requirements
- R1: For a write, `addr` and `byte_we_n` are taken on one enabled edge, and `wdata` is taken on the second enabled edge after it.
- R2: A read taken on an enabled edge drives its word on `rdata` with `rvalid` high after the second following enabled edge.
- R3: Reads, writes and deselects may be issued on every enabled edge in any order with correct results and no idle cycle.
- R4: When `ld_n` is high, the previous operation type continues on the next burst address. The upper address bits stay those of the base. With burst count n = 1,2,3,0,... the two low bits are (base+n) mod 4 when `burst_il`=0, and base XOR n when `burst_il`=1.
- R5: A load cycle selects the block only when `ce_n`=0, `ce_hi`=1 and `ce2_n`=0. Any other combination is a deselect, and bursts that continue a deselect stay deselected.
- R6: Byte lane k, `wdata` bits [9k+8:9k], is written only when `byte_we_n[k]`=0. Other lanes keep their contents.
- R7: A read returns the newest data for each lane, including lanes from up to two older writes still in staging. The younger write wins per lane.
- R8: While `clk_en_n` is high, all state and outputs hold, and every input, including `wdata`, is ignored.
- R9: `rdata_oe` equals `rvalid` AND NOT `oe_n`, combinationally, with no clock involved.
- R10: Reset clears all pipeline valid flags. Writes and deselects give `rvalid` low two enabled edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the pipeline flags |
| clk_en_n | input | 1 | Active-low clock enable; high suspends |
| ce_n | input | 1 | Active-low select |
| ce_hi | input | 1 | Active-high select |
| ce2_n | input | 1 | Second active-low select |
| ld_n | input | 1 | Low: load a new operation; high: burst continue |
| wr_n | input | 1 | Low: write, high: read (on load) |
| byte_we_n | input | 4 | Active-low per-lane write enables |
| burst_il | input | 1 | 1: interleaved burst order, 0: linear |
| addr | input | 8 | Word address |
| wdata | input | 36 | Write data, two enabled edges after address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | 36 | Registered read data |
| rvalid | output | 1 | Read data valid |
| rdata_oe | output | 1 | Drive enable for read data |

## Verification
The delicate collision is a read of an address on the same edge that the array commits one write to it and the write data of a second, younger write arrives on the bus. Forwarding and the array commit both act in that cycle. The bench sets this up with directed write–write–read sequences to one address with disjoint and overlapping lane masks. It then runs long random traffic over only sixteen addresses, with stalls inserted while writes are pending. Each returned word is compared with a program-order memory model that applies writes at issue time.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    // low address bits for burst step n from a base
    function automatic logic [1:0] burst_low(input logic [1:0] base,
                                             input logic [1:0] n,
                                             input logic       il);
        return il ? (base ^ n) : (base + n);
    endfunction

endpackage

// File: rtl/zbt_burst_gen.sv
module zbt_burst_gen
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              load,
    input  logic              sel,
    input  logic              wr,
    input  logic              il,
    input  logic [ADDR_W-1:0] addr_i,
    output op_e               op_o,
    output logic [ADDR_W-1:0] addr_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
        op_e               kind;
    } bst_t;

    bst_t       st_d, st_q;
    logic [1:0] cnt_nx;

    always_comb begin
        st_d   = st_q;
        cnt_nx = st_q.cnt + 2'd1;
        if (load) begin
            op_o   = sel ? (wr ? OP_WR : OP_RD) : OP_IDLE;
            addr_o = addr_i;
        end else begin
            op_o   = st_q.kind;
            addr_o = {st_q.base[ADDR_W-1:2], burst_low(st_q.base[1:0], cnt_nx, il)};
        end
        if (en) begin
            if (load) begin
                st_d.base = addr_i;
                st_d.cnt  = 2'd0;
                st_d.kind = op_o;
            end else begin
                st_d.cnt  = cnt_nx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_burst_adv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load) |=> (st_q.cnt == $past(st_q.cnt) + 2'd1));

endmodule

// File: rtl/zbt_fwd_merge.sv
module zbt_fwd_merge #(
    parameter  int LANES  = 4,
    parameter  int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic [DATA_W-1:0] base_i,
    input  logic              a_hit,
    input  logic [LANES-1:0]  a_be_n,
    input  logic [DATA_W-1:0] a_data,
    input  logic              b_hit,
    input  logic [LANES-1:0]  b_be_n,
    input  logic [DATA_W-1:0] b_data,
    output logic [DATA_W-1:0] merged_o
);

    // slot b is the younger write and wins per lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged_o[g*LANE_W +: LANE_W] =
            (b_hit && !b_be_n[g]) ? b_data[g*LANE_W +: LANE_W] :
            (a_hit && !a_be_n[g]) ? a_data[g*LANE_W +: LANE_W] :
                                    base_i[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
    parameter  int ADDR_W = 8,
    parameter  int LANES  = 4,
    parameter  int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] wa,
    input  logic [LANES-1:0]  we_lane_n,
    input  logic [DATA_W-1:0] wd,
    input  logic [ADDR_W-1:0] ra,
    output logic [DATA_W-1:0] rd
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && !we_lane_n[g]) begin
                mem[wa] <= wd[g*LANE_W +: LANE_W];
            end
        end

        assign rd[g*LANE_W +: LANE_W] = mem[ra];
    end

endmodule

// File: rtl/zbt_sram_core.sv
module zbt_sram_core
    import zbt_pkg::*;
#(
    parameter  int ADDR_W = 8,
    parameter  int LANES  = 4,
    parameter  int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              ce_n,
    input  logic              ce_hi,
    input  logic              ce2_n,
    input  logic              ld_n,
    input  logic              wr_n,
    input  logic [LANES-1:0]  byte_we_n,
    input  logic              burst_il,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              oe_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              rdata_oe
);

    typedef struct packed {
        logic              vld;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  be_n;
    } cmd_t;

    typedef struct packed {
        cmd_t              c;
        logic [DATA_W-1:0] data;
    } slot_t;

    typedef struct packed {
        cmd_t              s1;
        slot_t             s2;
        slot_t             cm;
        logic              out_vld;
        logic [DATA_W-1:0] out_data;
    } pipe_t;

    pipe_t             p_d, p_q;
    logic              en;
    logic              sel;
    op_e               op_k;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] arr_rd;
    logic [DATA_W-1:0] merged;
    logic              a_hit, b_hit;
    logic              arr_we;

    assign en  = !clk_en_n;
    assign sel = !ce_n && ce_hi && !ce2_n;

    zbt_burst_gen #(.ADDR_W(ADDR_W)) u_burst (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .load   (!ld_n),
        .sel    (sel),
        .wr     (!wr_n),
        .il     (burst_il),
        .addr_i (addr),
        .op_o   (op_k),
        .addr_o (op_addr)
    );

    assign arr_we = en && p_q.cm.c.vld && p_q.cm.c.wr;

    zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk       (clk),
        .we        (arr_we),
        .wa        (p_q.cm.c.addr),
        .we_lane_n (p_q.cm.c.be_n),
        .wd        (p_q.cm.data),
        .ra        (p_q.s1.addr),
        .rd        (arr_rd)
    );

    // slot a: write committing this edge; slot b: write whose data is on the bus now
    assign a_hit = p_q.cm.c.vld && p_q.cm.c.wr && (p_q.cm.c.addr == p_q.s1.addr);
    assign b_hit = p_q.s2.c.vld && p_q.s2.c.wr && (p_q.s2.c.addr == p_q.s1.addr);

    zbt_fwd_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
        .base_i   (arr_rd),
        .a_hit    (a_hit),
        .a_be_n   (p_q.cm.c.be_n),
        .a_data   (p_q.cm.data),
        .b_hit    (b_hit),
        .b_be_n   (p_q.s2.c.be_n),
        .b_data   (wdata),
        .merged_o (merged)
    );

    always_comb begin
        p_d = p_q;
        if (en) begin
            p_d.out_vld     = p_q.s2.c.vld && !p_q.s2.c.wr;
            p_d.out_data    = p_q.s2.data;
            p_d.cm.c        = p_q.s2.c;
            p_d.cm.c.vld    = p_q.s2.c.vld && p_q.s2.c.wr;
            p_d.cm.data     = wdata;
            p_d.s2.c        = p_q.s1;
            p_d.s2.data     = merged;
            p_d.s1.vld      = (op_k != OP_IDLE);
            p_d.s1.wr       = (op_k == OP_WR);
            p_d.s1.addr     = op_addr;
            p_d.s1.be_n     = byte_we_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign rdata    = p_q.out_data;
    assign rvalid   = p_q.out_vld;
    assign rdata_oe = p_q.out_vld && !oe_n;

    assert_rd_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && p_q.s2.c.vld && !p_q.s2.c.wr) |=> rvalid);

    assert_no_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !(p_q.s2.c.vld && !p_q.s2.c.wr)) |=> !rvalid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(rdata) && $stable(rvalid)));

    assert_wdata_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && p_q.s2.c.vld && p_q.s2.c.wr) |=>
            (p_q.cm.c.vld && (p_q.cm.data == $past(wdata))));

endmodule

// File: tb/zbt_sram_core_bench.sv
module zbt_sram_core_bench;

    localparam int AW = 8;
    localparam int DW = 36;
    localparam logic [2:0] SEL_ON  = 3'b010; // {ce_n, ce_hi, ce2_n}
    localparam logic [2:0] SEL_OFF = 3'b110;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          clk_en_n, ce_n, ce_hi, ce2_n, ld_n, wr_n, burst_il, oe_n;
    logic [3:0]    byte_we_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          rvalid, rdata_oe;

    always #2 clk = ~clk;

    zbt_sram_core u_zbt_sram_core (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .ce_n(ce_n), .ce_hi(ce_hi),
        .ce2_n(ce2_n), .ld_n(ld_n), .wr_n(wr_n), .byte_we_n(byte_we_n),
        .burst_il(burst_il), .addr(addr), .wdata(wdata), .oe_n(oe_n),
        .rdata(rdata), .rvalid(rvalid), .rdata_oe(rdata_oe)
    );

    typedef struct {
        bit          vld;
        bit          wr;
        bit [AW-1:0] a;
        bit [DW-1:0] d;
    } bop_t;

    bit [DW-1:0] mem_m [256];
    bop_t        p1, p2;
    bit          exp_vld;
    bit [DW-1:0] exp_d;
    bit [AW-1:0] b_base;
    bit [1:0]    b_cnt;
    int          b_kind;     // 0 deselect, 1 read, 2 write
    int          checks = 0;
    int          fails  = 0;
    string       tag = "R10";

    task automatic chk(input bit ok, input string req,
                       input logic [DW-1:0] act, input logic [DW-1:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, expv);
        end
    endtask

    function automatic bit [DW-1:0] rnd36();
        bit [63:0] t;
        t = {$urandom(), $urandom()};
        return t[DW-1:0];
    endfunction

    task automatic step(input bit en, input bit ld, input logic [2:0] sc, input bit wr,
                        input bit [3:0] be, input bit il, input bit [AW-1:0] a,
                        input bit [DW-1:0] wd, input bit oe);
        bop_t        n;
        bit [AW-1:0] ea;
        clk_en_n  = !en;
        ld_n      = !ld;
        {ce_n, ce_hi, ce2_n} = sc;
        wr_n      = !wr;
        byte_we_n = be;
        burst_il  = il;
        addr      = a;
        oe_n      = !oe;
        wdata     = (en && p2.vld && p2.wr) ? p2.d : rnd36();
        @(posedge clk);
        #1;
        if (en) begin
            if (ld) begin
                b_kind = (sc == SEL_ON) ? (wr ? 2 : 1) : 0;
                b_base = a;
                b_cnt  = 2'd0;
                ea     = a;
            end else begin
                b_cnt = b_cnt + 2'd1;
                ea    = {b_base[AW-1:2], il ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt)};
            end
            n.vld = (b_kind != 0);
            n.wr  = (b_kind == 2);
            n.a   = ea;
            n.d   = '0;
            if (b_kind == 2) begin
                n.d = wd;
                for (int k = 0; k < 4; k++)
                    if (!be[k]) mem_m[ea][k*9 +: 9] = wd[k*9 +: 9];
            end else if (b_kind == 1) begin
                n.d = mem_m[ea];
            end
            exp_vld = p2.vld && !p2.wr;
            exp_d   = p2.d;
            p2 = p1;
            p1 = n;
        end
        chk(rvalid === exp_vld, {tag, " R2 R10 rvalid"}, {35'd0, rvalid}, {35'd0, exp_vld});
        if (exp_vld) chk(rdata === exp_d, {tag, " rdata"}, rdata, exp_d);
        chk(rdata_oe === (exp_vld && oe), "R9 drive", {35'd0, rdata_oe}, {35'd0, exp_vld && oe});
        oe_n = ~oe_n;
        #0.5;
        chk(rdata_oe === (exp_vld && !oe), "R9 async", {35'd0, rdata_oe}, {35'd0, exp_vld && !oe});
    endtask

    task automatic wr1(input bit [AW-1:0] a, input bit [3:0] be, input bit [DW-1:0] d);
        step(1, 1, SEL_ON, 1, be, 0, a, d, 1);
    endtask

    task automatic rd1(input bit [AW-1:0] a);
        step(1, 1, SEL_ON, 0, 4'hF, 0, a, '0, 1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1, 1, SEL_OFF, 0, 4'hF, 0, '0, '0, 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        clk_en_n = 1'b0; ce_n = 1'b1; ce_hi = 1'b0; ce2_n = 1'b1; ld_n = 1'b0;
        wr_n = 1'b1; byte_we_n = 4'hF; burst_il = 1'b0; addr = '0; wdata = '0; oe_n = 1'b0;
        p1 = '{default: 0}; p2 = '{default: 0}; exp_vld = 0; exp_d = '0; b_kind = 0;
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        chk(rvalid === 1'b0, "R10 reset rvalid", {35'd0, rvalid}, '0);
        chk(rdata_oe === 1'b0, "R10 reset oe", {35'd0, rdata_oe}, '0);
        rst_n = 1'b1;
        #1;

        tag = "R1";
        for (int i = 0; i < 256; i++) wr1(i[7:0], 4'h0, rnd36());
        idle(3);

        tag = "R2";
        for (int i = 0; i < 16; i++) rd1(i[7:0]);
        idle(3);

        // R7: two pending writes, younger wins, disjoint and overlapping lanes
        tag = "R7";
        wr1(8'h20, 4'h0, rnd36());
        rd1(8'h20);
        wr1(8'h21, 4'b1100, rnd36());
        wr1(8'h21, 4'b1010, rnd36());
        rd1(8'h21);
        wr1(8'h22, 4'b0110, rnd36());
        rd1(8'h23);
        wr1(8'h22, 4'b1001, rnd36());
        rd1(8'h22);
        rd1(8'h22);
        idle(3);

        // R8: stalls while writes are pending, bus garbage during stall
        tag = "R8";
        wr1(8'h30, 4'h0, rnd36());
        step(0, 1, SEL_ON, 0, 4'h0, 0, 8'h30, rnd36(), 1);
        step(0, 0, SEL_ON, 1, 4'h0, 1, 8'h31, rnd36(), 1);
        rd1(8'h30);
        step(0, 1, SEL_ON, 1, 4'h0, 0, 8'h30, rnd36(), 0);
        wr1(8'h30, 4'b0111, rnd36());
        step(0, 1, SEL_ON, 1, 4'h0, 0, 8'h30, rnd36(), 1);
        rd1(8'h30);
        step(0, 1, SEL_ON, 1, 4'h0, 0, 8'h30, rnd36(), 1);
        idle(3);

        // R6: partial writes, read back later
        tag = "R6";
        for (int k = 0; k < 16; k++) wr1(8'h40 + k[7:0], k[3:0], rnd36());
        idle(2);
        for (int k = 0; k < 16; k++) rd1(8'h40 + k[7:0]);
        idle(3);

        // R4: bursts, linear and interleaved, read and write
        tag = "R4";
        for (int il = 0; il < 2; il++) begin
            for (int b = 0; b < 4; b++) begin
                step(1, 1, SEL_ON, 0, 4'hF, il[0], 8'h54 + b[7:0], '0, 1);
                for (int j = 0; j < 5; j++)
                    step(1, 0, SEL_OFF, 1, 4'h0, il[0], 8'hFF, '0, 1);
            end
            step(1, 1, SEL_ON, 1, 4'h0, il[0], 8'h66, rnd36(), 1);
            for (int j = 0; j < 3; j++)
                step(1, 0, SEL_OFF, 0, 4'b0101, il[0], 8'h00, rnd36(), 1);
            for (int j = 0; j < 4; j++) rd1(8'h64 + j[7:0]);
            idle(3);
        end

        // R5: every select combination, and continue after deselect
        tag = "R5";
        for (int s = 0; s < 8; s++) begin
            step(1, 1, s[2:0], 0, 4'hF, 0, 8'h05, '0, 1);
            step(1, 0, SEL_ON, 0, 4'hF, 0, 8'h05, '0, 1);
            step(1, 1, s[2:0], 1, 4'h0, 0, 8'h07, rnd36(), 1);
            idle(2);
            rd1(8'h07);
            idle(2);
        end

        // R3: random mixed traffic over a small address window
        tag = "R3";
        for (int i = 0; i < 3000; i++) begin
            bit en, ld, wr, il, oe;
            bit [3:0] be;
            logic [2:0] sc;
            en = ($urandom_range(99) < 85);
            ld = ($urandom_range(99) < 80);
            wr = $urandom_range(1);
            il = $urandom_range(1);
            oe = $urandom_range(1);
            be = ($urandom_range(1) != 0) ? 4'h0 : 4'($urandom_range(15));
            sc = ($urandom_range(99) < 85) ? SEL_ON : 3'($urandom_range(7));
            step(en, ld, sc, wr, be, il, 8'($urandom_range(15)), rnd36(), oe);
        end
        idle(4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule